// File: doc/BRIEF.md
# RS485 Direction-Sequenced UART Transmitter

This block is the transmit half of a UART meant to sit in front of a half-duplex RS485 transceiver. Software writes bytes into a four-entry transmit queue through a small byte-wide register port. The block sends them as 8N1 frames on `tx_o`. While it does so, it drives the transceiver's driver-enable pin (`dir_o`) on its own, so no software timer has to line the turnaround up with the last stop bit.

The line rate comes from a 16-bit divisor and an oversampling select. One bit lasts the divisor times 16 clocks, or the divisor times 13 clocks. A burst starts when a byte reaches an idle transmitter. The direction output goes to its sending level at once, and the start bit follows one bit time later. Bytes that are already queued follow each other with no gap. After the last stop bit, the direction output holds its sending level for three more bit times so the stop bit can clear the transceiver. If a byte arrives during that hold, the burst resumes without releasing the line. A mode register at offset 0x20 gates the direction output and sets its polarity. `idle_o` reports that the whole sequence is over.

Register map: 0x00 transmit data (write pushes one byte), 0x01 divisor low byte, 0x02 divisor high byte, 0x03 bit 0 selects 13x (1) or 16x (0) oversampling, 0x20 bit 4 direction enable and bit 3 direction polarity. All registers reset to zero. A write takes effect when `wr_en_i` is sampled high on a rising clock edge.

Top module: `rs485_uart_tx`

## Requirements
- R1: After reset, `tx_o` is 1, `dir_o` is 1 (the idle level for polarity 0), `idle_o` is 1, and the divisor is 0.
- R2: Each byte goes out as one low start bit, eight data bits LSB first and one high stop bit, and `tx_o` rests high between bursts.
- R3: One bit time is divisor×16 clocks when bit 0 of register 0x03 is 0, and divisor×13 clocks when it is 1.
- R4: When a byte is written to an idle transmitter, `dir_o` takes its sending level one clock after the write edge, and the start bit begins exactly one bit time after that.
- R5: After the last stop bit, `dir_o` keeps its sending level for exactly three bit times and then returns to idle; `idle_o` rises on the same clock.
- R6: Bit 3 of register 0x20 is the polarity. When it is 1, `dir_o` is high while sending and low at idle. When it is 0, the levels are reversed.
- R7: When bit 4 of register 0x20 is 0, `dir_o` stays at its idle level for the whole frame, and the frame is still sent.
- R8: Bytes already queued when a stop bit ends are sent next with no idle bit and no lead bit between frames, and `dir_o` stays at the sending level.
- R9: A byte written during the three-bit hold cancels the hold. `dir_o` stays at the sending level, and the new frame's start bit begins one bit time after the clock that follows the write.
- R10: While the divisor is 0, `tx_o` stays high and `dir_o` stays idle even with bytes queued. Writing a nonzero divisor then starts the burst as in R4, counted from that write.
- R11: The queue holds four bytes. A data write while the queue is full is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte offset |
| wdata_i | input | 8 | Register write data |
| tx_o | output | 1 | Serial data out, idles high |
| dir_o | output | 1 | Transceiver driver-enable |
| idle_o | output | 1 | Queue empty and direction sequence finished |

## Verification
On every cycle, the assertions check these rules:
- a low on `tx_o` with direction enabled always coincides with the sending level on `dir_o`;
- `idle_o` never rises while the line or the direction pin is still active;
- the sending level is released only from the last hold bit, and a burst only opens through the lead bit;
- a zero divisor never produces a bit tick;
- the queue never exceeds its depth.

Only the bench's scenarios can show the exact bit lengths for both oversampling modes, the bit order, the one-bit lead, the three-bit tail, back-to-back frames, cancelling the hold, discarding writes to a full queue, and the release of a burst held back by a zero divisor.

// File: rtl/rs485_tx_pkg.sv
package rs485_tx_pkg;
  localparam int DIV_W     = 16;
  localparam int PER_W     = DIV_W + 4;
  localparam int CNT_W     = 3;
  localparam int DATA_BITS = 8;
  localparam int HOLD_BITS = 3;

  localparam logic [5:0] ADDR_DATA   = 6'h00;
  localparam logic [5:0] ADDR_DIV_LO = 6'h01;
  localparam logic [5:0] ADDR_DIV_HI = 6'h02;
  localparam logic [5:0] ADDR_OSMODE = 6'h03;
  localparam logic [5:0] ADDR_DIRCFG = 6'h20;
  localparam int DIR_POL_BIT = 3;
  localparam int DIR_EN_BIT  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_START, ST_DATA, ST_STOP, ST_HOLD
  } tx_state_e;
endpackage

// File: rtl/rs485_tx_fifo.sv
module rs485_tx_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    count_q;
  logic             do_push, do_pop, full;

  assign full    = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      count_q <= count_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  assert_full_drops_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i) |=> (count_q == CW'(DEPTH)));
endmodule

// File: rtl/rs485_baud_gen.sv
module rs485_baud_gen
  import rs485_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             os13_i,
  input  logic             clr_i,
  output logic             tick_o
);
  logic [PER_W-1:0] cnt_q, period;
  logic             run;

  assign run    = (div_i != '0);
  assign period = os13_i ? PER_W'(div_i) * PER_W'(13) : PER_W'(div_i) << 4;
  assign tick_o = run && !clr_i && (cnt_q >= period - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || tick_o)  cnt_q <= '0;
    else if (run)              cnt_q <= cnt_q + 1'b1;
  end

  assert_no_tick_div0_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == '0) |-> !tick_o);
endmodule

// File: rtl/rs485_tx_ctrl.sv
module rs485_tx_ctrl
  import rs485_tx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 div_zero_i,
  input  logic                 q_empty_i,
  input  logic [DATA_BITS-1:0] q_data_i,
  output logic                 q_pop_o,
  output logic                 baud_clr_o,
  output logic                 tx_o,
  output logic                 active_o
);
  tx_state_e            state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [DATA_BITS-1:0] sh_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    q_pop_o = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (!q_empty_i && !div_zero_i) state_d = ST_LEAD;
      ST_LEAD:  if (tick_i) begin
                  state_d = ST_START;
                  q_pop_o = 1'b1;
                end
      ST_START: if (tick_i) begin
                  state_d = ST_DATA;
                  cnt_d   = '0;
                end
      ST_DATA:  if (tick_i) begin
                  if (cnt_q == CNT_W'(DATA_BITS - 1)) state_d = ST_STOP;
                  else cnt_d = cnt_q + 1'b1;
                end
      ST_STOP:  if (tick_i) begin
                  if (!q_empty_i) begin
                    state_d = ST_START;
                    q_pop_o = 1'b1;
                  end else begin
                    state_d = ST_HOLD;
                    cnt_d   = '0;
                  end
                end
      ST_HOLD:  if (!q_empty_i) state_d = ST_LEAD;
                else if (tick_i) begin
                  if (cnt_q == CNT_W'(HOLD_BITS - 1)) state_d = ST_IDLE;
                  else cnt_d = cnt_q + 1'b1;
                end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (q_pop_o)                        sh_q <= q_data_i;
      else if (state_q == ST_DATA && tick_i) sh_q <= {1'b1, sh_q[DATA_BITS-1:1]};
    end
  end

  // counter restarts at each burst and on hold cancel so the lead bit is whole
  assign baud_clr_o = (state_q == ST_IDLE) || (state_q == ST_HOLD && !q_empty_i);
  assign active_o   = (state_q != ST_IDLE);
  assign tx_o       = (state_q == ST_START) ? 1'b0 :
                      (state_q == ST_DATA)  ? sh_q[0] : 1'b1;

  assert_burst_opens_with_lead_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> (state_q == ST_LEAD));
  assert_release_after_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> ($past(state_q) == ST_HOLD && $past(cnt_q) == CNT_W'(HOLD_BITS - 1)));
  assert_hold_cancel_keeps_line_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !q_empty_i) |=> (state_q == ST_LEAD));
endmodule

// File: rtl/rs485_uart_tx.sv
module rs485_uart_tx
  import rs485_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [5:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic       tx_o,
  output logic       dir_o,
  output logic       idle_o
);
  logic [DIV_W-1:0]     div_q;
  logic                 os13_q, dir_en_q, dir_pol_q;
  logic                 push, pop, q_empty, tick, baud_clr, active;
  logic [DATA_BITS-1:0] q_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      os13_q    <= 1'b0;
      dir_en_q  <= 1'b0;
      dir_pol_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        ADDR_DIV_LO: div_q[7:0]       <= wdata_i;
        ADDR_DIV_HI: div_q[DIV_W-1:8] <= wdata_i[DIV_W-9:0];
        ADDR_OSMODE: os13_q           <= wdata_i[0];
        ADDR_DIRCFG: begin
          dir_en_q  <= wdata_i[DIR_EN_BIT];
          dir_pol_q <= wdata_i[DIR_POL_BIT];
        end
        default: ;
      endcase
    end
  end

  assign push = wr_en_i && (addr_i == ADDR_DATA);

  rs485_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_BITS)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (push),
    .data_i (wdata_i),
    .pop_i  (pop),
    .data_o (q_data),
    .empty_o(q_empty)
  );

  rs485_baud_gen u_baud (
    .clk_i, .rst_ni,
    .div_i (div_q),
    .os13_i(os13_q),
    .clr_i (baud_clr),
    .tick_o(tick)
  );

  rs485_tx_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .tick_i    (tick),
    .div_zero_i(div_q == '0),
    .q_empty_i (q_empty),
    .q_data_i  (q_data),
    .q_pop_o   (pop),
    .baud_clr_o(baud_clr),
    .tx_o      (tx_o),
    .active_o  (active)
  );

  assign dir_o  = (active && dir_en_q) ? dir_pol_q : !dir_pol_q;
  assign idle_o = !active && q_empty;

  assert_low_bit_inside_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_en_q && !tx_o) |-> (dir_o == dir_pol_q));
  assert_idle_is_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (tx_o && dir_o != dir_pol_q));
  assert_disabled_dir_static_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_en_q && $stable(dir_pol_q)) |-> $stable(dir_o));
  assert_div0_line_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == '0 && idle_o) |=> tx_o);
endmodule

// File: tb/rs485_uart_tx_tb.sv
module rs485_uart_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {div[15:0], os13, dir_en, dir_pol, data[7:0]}
  localparam logic [26:0] VECS [NVEC] = '{
    {16'd1, 1'b0, 1'b1, 1'b1, 8'hA5},
    {16'd1, 1'b1, 1'b1, 1'b0, 8'h3C},
    {16'd2, 1'b1, 1'b1, 1'b1, 8'h01},
    {16'd3, 1'b0, 1'b1, 1'b0, 8'h80},
    {16'd2, 1'b0, 1'b0, 1'b1, 8'hFF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic tx, dir, idle;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] bq [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  rs485_uart_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .tx_o(tx), .dir_o(dir), .idle_o(idle)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; write sampled at the next posedge; returns at the following negedge
  task automatic reg_wr(input logic [5:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic exp_tx(input int seg, input int nb);
    int f, b;
    if (seg < 1 || seg > 10*nb) return 1'b1;
    f = (seg - 1) / 10;
    b = (seg - 1) % 10;
    if (b == 0) return 1'b0;
    if (b == 9) return 1'b1;
    return bq[f][b-1];
  endfunction

  // reference edge E0 = first write; sample n = cycles after E0
  task automatic run_burst(input int p, input int nb, input int n0, input int n_end,
                           input logic en, input logic pol, input string tag);
    int last, etx, edir, eidl, ftx, fdir, fidl;
    logic atx, adir, aidl, xtx, xdir, xidl;
    last = (n_end > 0) ? n_end : (10*nb + 4)*p + 2;
    etx = 0; edir = 0; eidl = 0; ftx = -1; fdir = -1; fidl = -1;
    atx = 1'b1; adir = 1'b1; aidl = 1'b1; xtx = 1'b1; xdir = 1'b1; xidl = 1'b1;
    for (int n = n0; n <= last; n++) begin
      int seg;
      logic t, d, i;
      @(negedge clk);
      seg = (n - 1) / p;
      t = exp_tx(seg, nb);
      i = (seg >= 10*nb + 4);
      d = (en && !i) ? pol : !pol;
      if (tx !== t)   begin etx++;  if (ftx < 0)  begin ftx = n;  atx = tx;   xtx = t;  end end
      if (dir !== d)  begin edir++; if (fdir < 0) begin fdir = n; adir = dir; xdir = d; end end
      if (idle !== i) begin eidl++; if (fidl < 0) begin fidl = n; aidl = idle; xidl = i; end end
    end
    checks += 3;
    if (etx)  begin fails++; $display("FAIL %s tx cycle %0d actual=%b expected=%b", tag, ftx, atx, xtx); end
    if (edir) begin fails++; $display("FAIL %s dir cycle %0d actual=%b expected=%b", tag, fdir, adir, xdir); end
    if (eidl) begin fails++; $display("FAIL %s idle cycle %0d actual=%b expected=%b", tag, fidl, aidl, xidl); end
  endtask

  task automatic set_cfg(input logic [15:0] div, input logic os13, input logic en, input logic pol);
    reg_wr(6'h01, div[7:0]);
    reg_wr(6'h02, div[15:8]);
    reg_wr(6'h03, {7'b0, os13});
    reg_wr(6'h20, {3'b0, en, pol, 3'b0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 tx after reset", 32'(tx), 32'd1);
    check("R1 dir after reset", 32'(dir), 32'd1);
    check("R1 idle after reset", 32'(idle), 32'd1);

    // table: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] dv;
      logic os, en, pol;
      int p;
      dv  = VECS[v][26:11];
      os  = VECS[v][10];
      en  = VECS[v][9];
      pol = VECS[v][8];
      bq[0] = VECS[v][7:0];
      p = int'(dv) * (os ? 13 : 16);
      set_cfg(dv, os, en, pol);
      check(en ? "R6 idle level" : "R7 idle level", 32'(dir), 32'(!pol));
      reg_wr(6'h00, bq[0]);
      run_burst(p, 1, 1, 0, en, pol, en ? "R2 R3 R4 R5 R6" : "R7 R2 R3");
    end

    // R8 back-to-back frames
    set_cfg(16'd1, 1'b0, 1'b1, 1'b1);
    bq[0] = 8'h5A; bq[1] = 8'hC3;
    reg_wr(6'h00, bq[0]);
    reg_wr(6'h00, bq[1]);
    run_burst(16, 2, 2, 0, 1'b1, 1'b1, "R8 back-to-back");

    // R9 hold cancel: first frame into the middle of its hold
    bq[0] = 8'h96;
    reg_wr(6'h00, bq[0]);
    run_burst(16, 1, 1, 12*16, 1'b1, 1'b1, "R9 first frame");
    bq[0] = 8'h4E;
    reg_wr(6'h00, bq[0]);
    check("R9 dir held at cancel", 32'(dir), 32'd1);
    check("R9 idle low at cancel", 32'(idle), 32'd0);
    run_burst(16, 1, 1, 0, 1'b1, 1'b1, "R9 resumed frame");

    // R10 divisor zero holds the burst back
    set_cfg(16'd0, 1'b0, 1'b1, 1'b0);
    bq[0] = 8'h71;
    reg_wr(6'h00, bq[0]);
    begin
      int bad = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (tx !== 1'b1 || dir !== 1'b1) bad++;
      end
      check("R10 line quiet with divisor 0 (bad cycles)", 32'(bad), 32'd0);
    end
    reg_wr(6'h01, 8'd1);
    run_burst(16, 1, 1, 0, 1'b1, 1'b0, "R10 release after divisor");

    // R11 six writes into a four-entry queue
    set_cfg(16'd1, 1'b0, 1'b1, 1'b1);
    bq[0] = 8'h11; bq[1] = 8'h22; bq[2] = 8'h33; bq[3] = 8'h44;
    for (int k = 0; k < 4; k++) reg_wr(6'h00, bq[k]);
    reg_wr(6'h00, 8'h55);
    reg_wr(6'h00, 8'h66);
    run_burst(16, 4, 6, 0, 1'b1, 1'b1, "R11 full queue drops");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule